// File: doc/BRIEF.md
# Memory Map Chip-Select Decoder

This block sits between a processor's 16-bit address bus with an 8-bit data bus and a small set of memory devices. It decodes each address into one chip select and passes the read and write strobes on to the selected device only. The map is fixed. Two 1K×8 RAM banks sit at the bottom of the space. A 1K window after them is left empty. A four-byte register file follows, and a 4K×8 ROM fills the upper half of the decoded 8K.

The register file lives inside the block. Simple behavioural RAM and ROM models are included so the data path can be checked from end to end. The shared data bus is modelled as a read-data vector plus an output-enable. When the enable is low, the bus is released to high impedance at the pad. The enable is low when no device is selected, when the cycle is idle, and when the processor raises read and write together; that last case is flagged as illegal.

Top module: `memmap_decoder`

## Requirements
- R1: When any of address bits 15..13 is 1, no select output is high, `rdata_oe` is 0, `dev_rd` and `dev_wr` are 0, and a write changes no storage.
- R2: With bits 15..12 at 0, bits 11..10 = 00 selects RAM bank 0 (`sel_ram0`) and 01 selects RAM bank 1 (`sel_ram1`). Either bank is indexed by bits 9..0.
- R3: Addresses 0800h–0BFFh select nothing. A read there leaves `rdata_oe` at 0, and a write there changes neither RAM bank nor the register file.
- R4: Addresses 0C00h–0FFFh assert `sel_regs`. Only bits 1..0 pick one of four registers, so 0C04h–0FFFh alias onto 0C00h–0C03h.
- R5: Addresses 1000h–1FFFh assert `sel_rom` whatever bits 11..10 hold. A read returns byte `i[7:0] XOR {4'hA, i[11:8]}`, where i = address bits 11..0.
- R6: When rd=1, wr=0 and a device is selected, `rdata_oe` and `dev_rd` are 1 in the same cycle, and `rdata` carries that device's byte for the current address.
- R7: When wr=1, rd=0 and a RAM bank or the register file is selected, `dev_wr` is 1. `wdata` is stored at the rising clock edge and is returned by a later read of that location.
- R8: When rd=0 and wr=0, `rdata_oe`, `dev_rd` and `dev_wr` are 0 and `rdata` is 00h. Likewise, `rdata` is 00h whenever `rdata_oe` is 0.
- R9: When rd=1 and wr=1, `illegal` is 1, `rdata_oe`, `dev_rd` and `dev_wr` are 0, and no storage changes. `illegal` is 0 in every other case.
- R10: A write aimed at the ROM window leaves `dev_wr` at 0 and has no effect on later ROM reads.
- R11: A synchronous active-low reset clears all four registers to 00h. RAM contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the register file |
| addr | input | 16 | Processor address |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| wdata | input | 8 | Data driven by the processor during a write |
| rdata | output | 8 | Data returned on a read, 00h when not driving |
| rdata_oe | output | 1 | Bus drive enable; 0 means the bus is left at high impedance |
| sel_ram0 | output | 1 | Chip select of RAM bank 0 |
| sel_ram1 | output | 1 | Chip select of RAM bank 1 |
| sel_regs | output | 1 | Chip select of the register file |
| sel_rom | output | 1 | Chip select of the ROM |
| dev_rd | output | 1 | Read strobe passed to the selected device |
| dev_wr | output | 1 | Write strobe passed to a selected writable device |
| illegal | output | 1 | Read and write asserted together |

## Verification
Selects, strobes, `illegal`, `rdata_oe` and read data depend only on the current inputs. They are therefore due in the same cycle as the stimulus. The bench drives inputs on the falling edge and samples them 1 ns later, well before the next rising edge. A write takes effect at the first rising edge after it is driven. The bench updates its shadow copy at that edge and compares the stored value only on a later read cycle. Reset clearing is likewise checked by a read in the first cycle after `rst_n` returns high.

// File: rtl/memmap_pkg.sv
// Shared widths for the memory-map decoder.
// Assumes a 16-bit address and byte-wide data; the map layout is fixed.
package memmap_pkg;
    parameter int ADDR_W  = 16;
    parameter int DATA_W  = 8;
    parameter int RAM_AW  = 10;   // 1K per RAM bank
    parameter int REG_AW  = 2;    // four registers
    parameter int ROM_AW  = 12;   // 4K ROM
    parameter int NUM_RAM = 2;    // banks in the low 2K
    localparam int WIN_W  = 2;    // window select bits 11..10
endpackage

// File: rtl/mm_addr_decode.sv
// Combinational address decoder.
// Bits 15..13 globally enable; bit 12 picks ROM; bits 11..10 pick a 1K window.
// Assumes at most one select is ever high.
module mm_addr_decode
    import memmap_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_RAM-1:0] ram_sel,
    output logic               reg_sel,
    output logic               rom_sel
);
    logic glob_en;
    logic low_half;
    logic [WIN_W-1:0] win;

    assign glob_en  = (addr[ADDR_W-1:13] == '0);
    assign low_half = glob_en & ~addr[12];
    assign win      = addr[11:10];

    // one select per RAM window
    for (genvar g = 0; g < NUM_RAM; g++) begin : g_ramsel
        assign ram_sel[g] = low_half & (win == WIN_W'(g));
    end

    assign reg_sel = low_half & (win == {WIN_W{1'b1}});
    assign rom_sel = glob_en & addr[12];
endmodule

// File: rtl/mm_sram.sv
// Behavioural synchronous-write, asynchronous-read RAM bank.
// Contents are not reset; rst_n only qualifies the checker.
module mm_sram
    import memmap_pkg::*;
#(
    parameter int AW = RAM_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << AW;
    logic [DATA_W-1:0] mem [DEPTH];

    // capture a byte on a qualified write
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wd;
    end

    assign rd_q = mem[idx];

    // R7
    ram_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wd));
endmodule

// File: rtl/mm_regfile.sv
// Four-entry byte register file, cleared by synchronous active-low reset.
// Reads are combinational from the index.
module mm_regfile
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] idx,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd_q
);
    localparam int NREG = 1 << REG_AW;
    logic [NREG-1:0][DATA_W-1:0] q;

    // reset clear or indexed write
    always_ff @(posedge clk) begin
        if (!rst_n)  q      <= '0;
        else if (we) q[idx] <= wd;
    end

    assign rd_q = q[idx];

    // R7
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q[$past(idx)] == $past(wd));
    // R11
    reg_reset_chk: assert property (@(posedge clk)
        !rst_n |=> q == '0);
endmodule

// File: rtl/mm_rom.sv
// Behavioural ROM whose content is computed from the index.
// Byte i is i[7:0] XOR {4'hA, i[11:8]}; there is no write path.
module mm_rom
    import memmap_pkg::*;
(
    input  logic [ROM_AW-1:0] idx,
    output logic [DATA_W-1:0] rd_q
);
    // content function
    assign rd_q = idx[7:0] ^ {4'hA, idx[11:8]};
endmodule

// File: rtl/memmap_decoder.sv
// Top of the memory-map decoder: decodes, gates strobes, holds storage
// and muxes read data. Assumes one access per cycle, writes at clk rise.
module memmap_decoder
    import memmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              sel_ram0,
    output logic              sel_ram1,
    output logic              sel_regs,
    output logic              sel_rom,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              illegal
);
    logic [NUM_RAM-1:0]             ram_sel;
    logic                           reg_sel;
    logic                           rom_sel;
    logic [NUM_RAM-1:0][DATA_W-1:0] ram_q;
    logic [DATA_W-1:0]              reg_q;
    logic [DATA_W-1:0]              rom_q;
    logic rd_ok, wr_ok, any_sel, wr_target;

    mm_addr_decode u_dec (
        .addr    (addr),
        .ram_sel (ram_sel),
        .reg_sel (reg_sel),
        .rom_sel (rom_sel)
    );

    assign rd_ok     = rd & ~wr;
    assign wr_ok     = wr & ~rd;
    assign any_sel   = (|ram_sel) | reg_sel | rom_sel;
    assign wr_target = (|ram_sel) | reg_sel;

    // one RAM model per bank
    for (genvar g = 0; g < NUM_RAM; g++) begin : g_bank
        mm_sram #(.AW(RAM_AW)) u_ram (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_ok & ram_sel[g]),
            .idx   (addr[RAM_AW-1:0]),
            .wd    (wdata),
            .rd_q  (ram_q[g])
        );
    end

    mm_regfile u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_ok & reg_sel),
        .idx   (addr[REG_AW-1:0]),
        .wd    (wdata),
        .rd_q  (reg_q)
    );

    mm_rom u_rom (
        .idx  (addr[ROM_AW-1:0]),
        .rd_q (rom_q)
    );

    assign sel_ram0 = ram_sel[0];
    assign sel_ram1 = ram_sel[1];
    assign sel_regs = reg_sel;
    assign sel_rom  = rom_sel;
    assign illegal  = rd & wr;
    assign rdata_oe = rd_ok & any_sel;
    assign dev_rd   = rdata_oe;
    assign dev_wr   = wr_ok & wr_target;

    // steer the selected device onto the read bus
    always_comb begin
        rdata = '0;
        if (rdata_oe) begin
            if (rom_sel)      rdata = rom_q;
            else if (reg_sel) rdata = reg_q;
            for (int i = 0; i < NUM_RAM; i++) begin
                if (ram_sel[i]) rdata = ram_q[i];
            end
        end
    end

    // R1
    hi_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:13] != 3'b0) |-> !(sel_ram0 | sel_ram1 | sel_regs | sel_rom | rdata_oe | dev_wr));
    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_ram0, sel_ram1, sel_regs, sel_rom}));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !wr) |-> (!rdata_oe && !dev_rd && !dev_wr && rdata == '0));
    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rdata_oe && !dev_wr && !dev_rd));
    // R10
    rom_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rom |-> !dev_wr);
endmodule

// File: tb/test_memmap_decoder.sv
module test_memmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe, sel_ram0, sel_ram1, sel_regs, sel_rom;
    logic        dev_rd, dev_wr, illegal;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] m_ram [2][1024];
    bit         m_val [2][1024];
    logic [7:0] m_reg [4];

    always #2.5 clk = ~clk;

    memmap_decoder i_memmap_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
        .sel_ram0(sel_ram0), .sel_ram1(sel_ram1), .sel_regs(sel_regs),
        .sel_rom(sel_rom), .dev_rd(dev_rd), .dev_wr(dev_wr), .illegal(illegal)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected select vector {rom, regs, ram1, ram0} from the map
    function automatic logic [3:0] exp_sel(input logic [15:0] a);
        if (a[15:13] != 3'b0) return 4'b0000;       // R1
        if (a[12])            return 4'b1000;       // R5
        case (a[11:10])
            2'b00:   return 4'b0001;                // R2
            2'b01:   return 4'b0010;                // R2
            2'b10:   return 4'b0000;                // R3
            default: return 4'b0100;                // R4
        endcase
    endfunction

    function automatic logic [7:0] rom_byte(input logic [11:0] i);
        return i[7:0] ^ {4'hA, i[11:8]};
    endfunction

    function automatic string tag_of(input logic [15:0] a, input logic r, input logic w);
        logic [3:0] s;
        s = exp_sel(a);
        if (r && w) return "R9";
        if (!r && !w) return "R8";
        if (a[15:13] != 3'b0) return "R1";
        if (s == 4'b0000) return "R3";
        if (s[3]) return w ? "R10" : "R5";
        if (s[2]) return w ? "R7" : "R4";
        return w ? "R7" : "R6";
    endfunction

    // one bus cycle: drive at falling edge, check combinational results, commit at rise
    task automatic bus(input logic [15:0] a, input logic r, input logic w, input logic [7:0] d);
        logic [3:0] s;
        bit         oe_e, wr_e, known;
        logic [7:0] de;
        string      t;
        @(negedge clk);
        addr = a; rd = r; wr = w; wdata = d;
        #1;
        s     = exp_sel(a);
        t     = tag_of(a, r, w);
        oe_e  = r && !w && (s != 4'b0000);
        wr_e  = w && !r && (s[0] || s[1] || s[2]);
        known = 1'b1;
        de    = 8'h00;
        if (oe_e) begin
            if (s[3])      de = rom_byte(a[11:0]);
            else if (s[2]) de = m_reg[a[1:0]];
            else begin
                de    = m_ram[s[1]][a[9:0]];
                known = m_val[s[1]][a[9:0]];
            end
        end
        chk({sel_rom, sel_regs, sel_ram1, sel_ram0} == s, t,
            {28'b0, sel_rom, sel_regs, sel_ram1, sel_ram0}, {28'b0, s});
        chk(rdata_oe == oe_e && dev_rd == oe_e, t, {30'b0, rdata_oe, dev_rd}, {30'b0, oe_e, oe_e});
        chk(dev_wr == wr_e, t, {31'b0, dev_wr}, {31'b0, wr_e});
        chk(illegal == (r && w), "R9", {31'b0, illegal}, {31'b0, r && w});
        if (known) chk(rdata == de, t, {24'b0, rdata}, {24'b0, de});
        @(posedge clk);
        if (wr_e) begin
            if (s[2]) m_reg[a[1:0]] = d;
            else begin
                m_ram[s[1]][a[9:0]] = d;
                m_val[s[1]][a[9:0]] = 1'b1;
            end
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        checks++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] a;
        logic [3:0]  pick;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        for (int b = 0; b < 2; b++)
            for (int j = 0; j < 1024; j++) m_val[b][j] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: registers read 00h after reset
        for (int i = 0; i < 4; i++) bus(16'h0C00 + 16'(i), 1'b1, 1'b0, 8'h00);

        // R2, R6, R7: write then read both banks at edges of each window
        bus(16'h0000, 1'b0, 1'b1, 8'h11);
        bus(16'h03FF, 1'b0, 1'b1, 8'h22);
        bus(16'h0400, 1'b0, 1'b1, 8'h33);
        bus(16'h07FF, 1'b0, 1'b1, 8'h44);
        bus(16'h0000, 1'b1, 1'b0, 8'h00);
        bus(16'h03FF, 1'b1, 1'b0, 8'h00);
        bus(16'h0400, 1'b1, 1'b0, 8'h00);
        bus(16'h07FF, 1'b1, 1'b0, 8'h00);

        // R3: write into the hole, then confirm RAM at the same index is intact
        bus(16'h0800, 1'b0, 1'b1, 8'hEE);
        bus(16'h0BFF, 1'b0, 1'b1, 8'hEE);
        bus(16'h0800, 1'b1, 1'b0, 8'h00);
        bus(16'h0000, 1'b1, 1'b0, 8'h00);
        bus(16'h03FF, 1'b1, 1'b0, 8'h00);

        // R4: alias writes land on the four registers
        bus(16'h0FFD, 1'b0, 1'b1, 8'hA5);
        bus(16'h0C01, 1'b1, 1'b0, 8'h00);
        bus(16'h0C06, 1'b0, 1'b1, 8'h5A);
        bus(16'h0C02, 1'b1, 1'b0, 8'h00);

        // R5, R10: ROM reads, attempted write, re-read
        bus(16'h1000, 1'b1, 1'b0, 8'h00);
        bus(16'h1FFF, 1'b1, 1'b0, 8'h00);
        bus(16'h1C34, 1'b0, 1'b1, 8'h00);
        bus(16'h1C34, 1'b1, 1'b0, 8'h00);

        // R9: illegal on RAM and register, no change afterwards
        bus(16'h0000, 1'b1, 1'b1, 8'h99);
        bus(16'h0C01, 1'b1, 1'b1, 8'h99);
        bus(16'h0000, 1'b1, 1'b0, 8'h00);
        bus(16'h0C01, 1'b1, 1'b0, 8'h00);

        // R1: upper bits set, write must not alias into RAM
        bus(16'h2000, 1'b0, 1'b1, 8'h77);
        bus(16'hE3FF, 1'b1, 1'b0, 8'h00);
        bus(16'h0000, 1'b1, 1'b0, 8'h00);

        // R8: idle cycles
        bus(16'h0400, 1'b0, 1'b0, 8'hFF);
        bus(16'h1234, 1'b0, 1'b0, 8'hFF);

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            pick = 4'($urandom % 16);
            a    = (pick == 4'd0) ? 16'($urandom) : {3'b000, 13'($urandom)};
            bus(a, 1'($urandom), 1'($urandom), 8'($urandom));
        end

        // R11: reset mid-run clears registers again
        bus(16'h0C03, 1'b0, 1'b1, 8'hC3);
        @(negedge clk) begin rst_n = 1'b0; rd = 1'b0; wr = 1'b0; end
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_reg[i] = 8'h00;
        bus(16'h0C03, 1'b1, 1'b0, 8'h00);
        bus(16'h0C00, 1'b1, 1'b0, 8'h00);

        finish_run();
    end
endmodule